// File: doc/BRIEF.md
# LVDS Pixel Pattern Packer

This block turns a stream of 8-bit palette indices into a dense stream of 28-bit serialiser patterns for a four-lane LVDS transmitter. Input arrives as 32-bit words, each carrying four indices, and the lowest byte is the earliest pixel. Every index is looked up in a 256-entry palette. Each entry holds one pixel's pattern, seven bit-times on each of four lanes. The patterns are laid end to end with no gaps and are cut into 32-bit output words, so eight pixels fill exactly seven output words.

Both stream ports use a valid/ready handshake. A separate write port loads or changes palette entries. A flag on the last input word of a line makes the block emit any partial final word, padded with zeros. The next line then starts again at bit 0 of a fresh output word. The block works on one input word at a time and issues one pixel lookup per clock. This gives 1.25 clocks per pixel, well inside the 14-clock budget of a 20 MHz pixel rate on a 280 MHz clock.

Top module: `lvds_pattern_packer`

## Requirements
- R1: Byte 0 of an input word is the first pixel. The first output word of a line holds the whole pattern of pixel 0 in bits 27:0 and bits 3:0 of pixel 1's pattern in bits 31:28.
- R2: Each pixel index selects the 28-bit palette entry at that index, and that entry is the pixel's pattern.
- R3: Patterns are concatenated with no gap, each starting at the bit after the previous one. A line of N input words gives ceil(112·N/32) output words, which is seven words per eight pixels.
- R4: When a word marked end-of-line has been packed, a partial last word is emitted with zeros above the final pattern. The next line starts at bit 0 of a new word, and no input is accepted while that flush is pending.
- R5: While the output is valid and not ready, the output stays valid and its data does not change.
- R6: Output words appear in stream order, with none lost and none repeated, under any pattern of back-pressure.
- R7: A palette write applies to every lookup made after the clock edge that performs it.
- R8: Only one input word is in flight: in the cycle after any input handshake, input ready is low. With the output always ready, a line of N words is fully delivered within 5·N+10 clocks.
- R9: After reset the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_wr_en | input | 1 | Palette write strobe |
| pal_wr_idx | input | PIX_W | Palette entry to write |
| pal_wr_pat | input | PAT_W | Pattern to store |
| word_valid | input | 1 | Input word valid |
| word_ready | output | 1 | Input word accepted when high with word_valid |
| word_data | input | WORD_W | Four pixel indices, byte 0 first |
| word_eol | input | 1 | This word ends the line |
| pack_valid | output | 1 | Output word valid |
| pack_ready | input | 1 | Downstream takes the output word |
| pack_data | output | WORD_W | Packed pattern bits, earliest bit in bit 0 |

## Verification
An input word is taken at the edge where valid and ready are both high. Its four pixels are looked up on the next four edges. A full output word is registered at the edge after the lookup that completes it, so the first word of a line appears three edges after acceptance. The bench drives and samples half a clock away from the rising edge, after the signals have settled. It predicts what happens at the next edge from the values seen then, and pops a behavioural bit-stream model's word at every output handshake. Stall stability is checked on the cycle after each refused output. The delivery bound is checked by counting clocks from the first drive to the last handshake.

// File: rtl/lvds_pack_pkg.sv
package lvds_pack_pkg;
   // lanes and bit-times making up one pixel pattern
   localparam int LVDS_LANES     = 4;
   localparam int LVDS_BIT_TIMES = 7;
   localparam int LVDS_PAT_W     = LVDS_LANES * LVDS_BIT_TIMES;

   // packer phases
   typedef enum logic {
      PK_RUN   = 1'b0,
      PK_FLUSH = 1'b1
   } pack_phase_e;
endpackage

// File: rtl/lvds_pal_mem.sv
module lvds_pal_mem #(
   parameter int IDX_W          = 8,
   parameter int PAT_W          = 28,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [PAT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [PAT_W-1:0] rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
         $error("lvds_pal_mem: IDX_W out of range");
      end
   endgenerate

   logic [PAT_W-1:0] mem_q [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (wr_en) begin
               mem_q[wr_addr] <= wr_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en) mem_q[wr_addr] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/lvds_pix_seq.sv
module lvds_pix_seq #(
   parameter int WORD_W = 32,
   parameter int PIX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_off,
   input  logic              word_valid,
   output logic              word_ready,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_eol,
   output logic              pix_valid,
   output logic [PIX_W-1:0]  pix_index,
   output logic              pix_eol,
   input  logic              pix_take
);
   localparam int NPIX   = WORD_W / PIX_W;
   localparam int SLOT_W = (NPIX > 1) ? $clog2(NPIX) : 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NPIX - 1);

   logic              held_q;
   logic              eol_q;
   logic [SLOT_W-1:0] slot_q;
   logic [WORD_W-1:0] word_q;
   logic              accept;

   assign word_ready = !held_q && !hold_off;
   assign accept     = word_valid && word_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         eol_q  <= 1'b0;
         slot_q <= '0;
         word_q <= '0;
      end else if (accept) begin
         held_q <= 1'b1;
         eol_q  <= word_eol;
         slot_q <= '0;
         word_q <= word_data;
      end else if (pix_take) begin
         word_q <= word_q >> PIX_W;
         if (slot_q == LAST_SLOT) begin
            held_q <= 1'b0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign pix_valid = held_q;
   assign pix_index = word_q[PIX_W-1:0];
   assign pix_eol   = eol_q && (slot_q == LAST_SLOT);
endmodule

// File: rtl/lvds_bit_packer.sv
module lvds_bit_packer
   import lvds_pack_pkg::*;
#(
   parameter int PAT_W  = 28,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pat_valid,
   input  logic [PAT_W-1:0]  pat_data,
   input  logic              pat_eol,
   output logic              pat_take,
   output logic              flushing,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data
);
   localparam int ACC_W  = PAT_W + WORD_W;
   localparam int FILL_W = $clog2(ACC_W + 1);
   localparam logic [FILL_W-1:0] WORD_F = FILL_W'(WORD_W);
   localparam logic [FILL_W-1:0] PAT_F  = FILL_W'(PAT_W);
   localparam logic [FILL_W-1:0] ROOM_F = FILL_W'(ACC_W - PAT_W);

   logic [ACC_W-1:0]  acc_q, acc_a, acc_n;
   logic [FILL_W-1:0] fill_q, fill_a, fill_n;
   pack_phase_e       phase_q;
   logic              ov_q;
   logic [WORD_W-1:0] od_q;
   logic              out_free, pop;

   always_comb begin
      out_free = !ov_q || out_ready;
      pop      = out_free && ((fill_q >= WORD_F) ||
                              ((phase_q == PK_FLUSH) && (fill_q != '0)));
      acc_a    = pop ? (acc_q >> WORD_W) : acc_q;
      if (!pop)                 fill_a = fill_q;
      else if (fill_q >= WORD_F) fill_a = fill_q - WORD_F;
      else                      fill_a = '0;
      pat_take = pat_valid && (phase_q == PK_RUN) && (fill_a <= ROOM_F);
      acc_n    = pat_take ? (acc_a | (ACC_W'(pat_data) << fill_a)) : acc_a;
      fill_n   = pat_take ? (fill_a + PAT_F) : fill_a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         fill_q  <= '0;
         phase_q <= PK_RUN;
         ov_q    <= 1'b0;
         od_q    <= '0;
      end else begin
         acc_q  <= acc_n;
         fill_q <= fill_n;
         if (pat_take && pat_eol)                          phase_q <= PK_FLUSH;
         else if ((phase_q == PK_FLUSH) && (fill_n == '0)) phase_q <= PK_RUN;
         if (pop) begin
            ov_q <= 1'b1;
            od_q <= acc_q[WORD_W-1:0];
         end else if (out_ready) begin
            ov_q <= 1'b0;
         end
      end
   end

   assign flushing  = (phase_q == PK_FLUSH);
   assign out_valid = ov_q;
   assign out_data  = od_q;
endmodule

// File: rtl/lvds_pattern_packer.sv
module lvds_pattern_packer #(
   parameter int PIX_W     = 8,
   parameter int PAT_W     = lvds_pack_pkg::LVDS_PAT_W,
   parameter int WORD_W    = 32,
   parameter bit PAL_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pal_wr_en,
   input  logic [PIX_W-1:0]  pal_wr_idx,
   input  logic [PAT_W-1:0]  pal_wr_pat,
   input  logic              word_valid,
   output logic              word_ready,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_eol,
   output logic              pack_valid,
   input  logic              pack_ready,
   output logic [WORD_W-1:0] pack_data
);
   localparam int NPIX   = WORD_W / PIX_W;
   localparam int ACC_W  = PAT_W + WORD_W;
   localparam int FILL_W = $clog2(ACC_W + 1);

   generate
      if ((WORD_W % PIX_W) != 0 || NPIX < 2) begin : g_bad_ratio
         $error("lvds_pattern_packer: WORD_W must hold two or more whole indices");
      end
      if (PAT_W < 1) begin : g_bad_pat
         $error("lvds_pattern_packer: PAT_W must be positive");
      end
   endgenerate

   logic             hold_off;
   logic             pix_valid, pix_eol, pix_take;
   logic [PIX_W-1:0] pix_index;
   logic [PAT_W-1:0] pix_pat;

   lvds_pix_seq #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_off   (hold_off),
      .word_valid (word_valid),
      .word_ready (word_ready),
      .word_data  (word_data),
      .word_eol   (word_eol),
      .pix_valid  (pix_valid),
      .pix_index  (pix_index),
      .pix_eol    (pix_eol),
      .pix_take   (pix_take)
   );

   lvds_pal_mem #(.IDX_W(PIX_W), .PAT_W(PAT_W), .CLEAR_ON_RESET(PAL_CLEAR)) u_pal (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pal_wr_en),
      .wr_addr (pal_wr_idx),
      .wr_data (pal_wr_pat),
      .rd_addr (pix_index),
      .rd_data (pix_pat)
   );

   lvds_bit_packer #(.PAT_W(PAT_W), .WORD_W(WORD_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .pat_valid (pix_valid),
      .pat_data  (pix_pat),
      .pat_eol   (pix_eol),
      .pat_take  (pix_take),
      .flushing  (hold_off),
      .out_valid (pack_valid),
      .out_ready (pack_ready),
      .out_data  (pack_data)
   );
endmodule

// File: rtl/lvds_pattern_packer_chk.sv
module lvds_pattern_packer_chk #(
   parameter int WORD_W = 32,
   parameter int ACC_W  = 60,
   parameter int FILL_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_valid,
   input logic              word_ready,
   input logic              word_eol,
   input logic              pack_valid,
   input logic              pack_ready,
   input logic [WORD_W-1:0] pack_data,
   input logic [FILL_W-1:0] fill
);
   // R4
   eol_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready && word_eol) |=> !word_ready);

   // R8
   one_word_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready) |=> !word_ready);

   // R5
   stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_valid && !pack_ready) |=> pack_valid);

   // R5
   stall_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_valid && !pack_ready) |=> $stable(pack_data));

   // R3
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(ACC_W));
endmodule

bind lvds_pattern_packer lvds_pattern_packer_chk #(
   .WORD_W (WORD_W),
   .ACC_W  (ACC_W),
   .FILL_W (FILL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_valid (word_valid),
   .word_ready (word_ready),
   .word_eol   (word_eol),
   .pack_valid (pack_valid),
   .pack_ready (pack_ready),
   .pack_data  (pack_data),
   .fill       (u_pack.fill_q)
);

// File: tb/lvds_pattern_packer_test.sv
module lvds_pattern_packer_test;
   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pal_wr_en = 1'b0;
   logic [7:0]  pal_wr_idx = '0;
   logic [27:0] pal_wr_pat = '0;
   logic        word_valid = 1'b0;
   logic        word_ready;
   logic [31:0] word_data = '0;
   logic        word_eol = 1'b0;
   logic        pack_valid;
   logic        pack_ready = 1'b1;
   logic [31:0] pack_data;

   lvds_pattern_packer uut (
      .clk(clk), .rst_n(rst_n),
      .pal_wr_en(pal_wr_en), .pal_wr_idx(pal_wr_idx), .pal_wr_pat(pal_wr_pat),
      .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
      .word_eol(word_eol),
      .pack_valid(pack_valid), .pack_ready(pack_ready), .pack_data(pack_data)
   );

   always #(CLK_PER/2) clk = ~clk;

   int          n_chk = 0;
   int          n_err = 0;
   bit          done  = 1'b0;
   logic [27:0] pal_m [256];
   logic [31:0] exp_q [$];
   logic [31:0] got_q [$];
   logic [31:0] line_q [$];
   logic [31:0] seed = 32'h1234_5678;

   function automatic logic [31:0] next_rand();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   function automatic logic [27:0] pat_of(input logic [7:0] i);
      return {i, ~i, i ^ 8'h5A, i[3:0]};
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic pal_write(input logic [7:0] idx, input logic [27:0] val);
      @(negedge clk);
      pal_wr_en  = 1'b1;
      pal_wr_idx = idx;
      pal_wr_pat = val;
      pal_m[idx] = val;
      @(negedge clk);
      pal_wr_en  = 1'b0;
   endtask

   // behavioural bit-stream model of one line
   task automatic build_expected();
      logic [63:0] bits = '0;
      int          cnt  = 0;
      foreach (line_q[w]) begin
         for (int p = 0; p < 4; p++) begin
            logic [7:0] idx = line_q[w][8*p +: 8];
            bits = bits | ({36'b0, pal_m[idx]} << cnt);
            cnt  = cnt + 28;
            while (cnt >= 32) begin
               exp_q.push_back(bits[31:0]);
               bits = bits >> 32;
               cnt  = cnt - 32;
            end
         end
      end
      if (cnt > 0) exp_q.push_back(bits[31:0]);
   endtask

   // mode 0: output always ready, 1: random back-pressure
   task automatic run_line(input int mode, output int cycles);
      int          sent  = 0;
      int          n     = line_q.size();
      bit          stall = 1'b0;
      logic [31:0] held  = '0;
      cycles = 0;
      got_q.delete();
      build_expected();
      while (sent < n || exp_q.size() > 0) begin
         @(negedge clk);
         word_valid = (sent < n);
         word_data  = (sent < n) ? line_q[sent] : 32'h0;
         word_eol   = (sent == n - 1);
         pack_ready = (mode == 0) ? 1'b1 : next_rand()[9];
         #1;
         if (stall) begin
            // R5: stalled word held and unchanged
            check(pack_valid && (pack_data == held), "R5 stalled output", pack_data, held);
         end
         stall = pack_valid && !pack_ready;
         held  = pack_data;
         if (word_valid && word_ready) sent++;
         if (pack_valid && pack_ready) begin
            got_q.push_back(pack_data);
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected extra word", pack_data, 32'h0);
            end else begin
               logic [31:0] e = exp_q.pop_front();
               // R2 R3 R6: value and order from palette and packing model
               check(pack_data == e, "R6 ordered packed word", pack_data, e);
            end
         end
         cycles++;
      end
      @(negedge clk);
      word_valid = 1'b0;
      word_eol   = 1'b0;
      pack_ready = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PER * 150000);
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog expired: got hang expected completion");
      finish_run();
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R9
      check(!pack_valid, "R9 output idle after reset", {31'b0, pack_valid}, 32'h0);
      check(word_ready,  "R9 input ready after reset", {31'b0, word_ready}, 32'h1);

      for (int i = 0; i < 256; i++) pal_write(8'(i), pat_of(8'(i)));

      // R1 R3: two words, fixed indices
      line_q = '{32'h4433_2211, 32'h8877_6655};
      run_line(0, cyc);
      check(got_q.size() == 7, "R3 eight pixels make seven words", got_q.size(), 7);
      check(got_q[0] == {pat_of(8'h22)[3:0], pat_of(8'h11)}, "R1 first word layout",
            got_q[0], {pat_of(8'h22)[3:0], pat_of(8'h11)});
      check(got_q[6][31:4] == pat_of(8'h88), "R3 last pattern ends word seven",
            {4'h0, got_q[6][31:4]}, {4'h0, pat_of(8'h88)});

      // R4: one-word line leaves 16 bits, padded
      line_q = '{32'h0403_0201};
      run_line(0, cyc);
      check(got_q.size() == 4, "R4 partial word flushed", got_q.size(), 4);
      check(got_q[3][31:16] == 16'h0, "R4 zero padding", {16'h0, got_q[3][31:16]}, 32'h0);

      // R4: next line restarts at bit 0
      line_q = '{32'h0D0C_0B0A, 32'h0102_0304};
      run_line(1, cyc);
      check(got_q[0] == {pat_of(8'h0B)[3:0], pat_of(8'h0A)}, "R4 new line starts at bit 0",
            got_q[0], {pat_of(8'h0B)[3:0], pat_of(8'h0A)});

      // R4: odd word count, 336 bits -> 11 words
      line_q = '{32'hFFEE_DDCC, 32'h0000_FF00, 32'h7F80_01FE};
      run_line(1, cyc);
      check(got_q.size() == 11, "R4 three-word line word count", got_q.size(), 11);

      // R5 R6: random data, heavy back-pressure
      line_q.delete();
      for (int w = 0; w < 12; w++) line_q.push_back(next_rand());
      run_line(1, cyc);
      check(got_q.size() == 42, "R6 all words delivered", got_q.size(), 42);

      // R7: palette change applies to later lookups
      pal_write(8'h11, 28'h0AB_CDEF);
      line_q = '{32'h1111_1111, 32'h2211_1122};
      run_line(0, cyc);
      check(got_q[0][27:0] == 28'h0AB_CDEF, "R7 new palette entry used",
            {4'h0, got_q[0][27:0]}, 32'h0AB_CDEF);

      // R8: sustained rate with output always ready
      line_q.delete();
      for (int w = 0; w < 16; w++) line_q.push_back(next_rand());
      run_line(0, cyc);
      check(cyc <= 5 * 16 + 10, "R8 throughput bound", cyc, 5 * 16 + 10);
      check(got_q.size() == 56, "R3 sixteen words give 56", got_q.size(), 56);

      check(exp_q.size() == 0, "R6 nothing left pending", exp_q.size(), 0);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule